// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block watches three digital flags from external supply comparators: supply under the warning level, supply under the minimum operating level, and supply under the backup battery level. It turns them into a graded response. The first level is an early-warning interrupt that software may enable; normal operation continues while it is pending. The second level is a reset state, which the block also reports by pulling a shared reset line low. The third level is a flag that reports switchover to the backup battery. The shared reset line works in both directions. Any device that pulls it low puts this block into reset, so several devices on one board can leave reset together.

When every reset cause has cleared, the reset state stays asserted for a fixed power-on delay before it releases. A falling edge on the program-request input gives a one-cycle bootstrap-load request. All comparator flags, the sampled line level and the program-request input are asynchronous. Each one is resynchronized before use.

Top module: `pfs_supervisor`

## Requirements
- R1: Each asynchronous input (the three comparator flags, the shared line level and the program request) passes through a two-flop synchronizer. A change applied before clock edge E0 shows at the registered outputs only after edge E2, and has no effect after E1.
- R2: When the warning flag is high, the enable is high and the request is armed, `warn_irq` sets. `warn_irq_vec` reads 8'h2B while the request is pending and 8'h00 otherwise. If the enable is low, the request does not set. Raising the enable later, while the flag is still high, sets it one edge later.
- R3: A one-cycle `warn_irq_ack` clears the pending request on the next edge. The request can set again only after the synchronized warning flag has been low for at least one cycle. If a new set and an acknowledge fall on the same edge, the set wins.
- R4: While the synchronized minimum-level flag is high, `rst_line_pull_low` is 1 and `sys_reset` is 1.
- R5: A low level on `rst_line_in` that comes from outside forces `sys_reset` to 1 and does not assert `rst_line_pull_low`.
- R6: After every reset cause has cleared, including the echo of the block's own pull on the line, `sys_reset` stays 1 for exactly POR_CYCLES more cycles (21,504 by default) and then goes to 0.
- R7: If any reset cause returns before the delay has run out, the delay count restarts from zero.
- R8: `mains_ok` is 0 while the synchronized battery-level flag is high and 1 otherwise.
- R9: A falling edge of the synchronized `prog_req_n_a` gives `boot_req` high for exactly one cycle. A rising edge gives no pulse.
- R10: After `rst_n`, `sys_reset` is 1, `warn_irq`, `boot_req` and `rst_line_pull_low` are 0, `mains_ok` is 1, and the power-on delay runs from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| vwarn_low_a | input | 1 | Comparator: supply below warning level (async) |
| vmin_low_a | input | 1 | Comparator: supply below minimum operating level (async) |
| vbat_low_a | input | 1 | Comparator: supply below battery level (async) |
| warn_irq_en | input | 1 | Enable for the early-warning interrupt |
| warn_irq_ack | input | 1 | One-cycle acknowledge that clears the pending warning |
| prog_req_n_a | input | 1 | Active-low bootstrap request, falling-edge sensitive (async) |
| rst_line_in | input | 1 | Sampled level of the shared open-drain reset line (async) |
| warn_irq | output | 1 | Pending early-warning interrupt request |
| warn_irq_vec | output | 8 | Interrupt vector, 8'h2B while pending, else 0 |
| sys_reset | output | 1 | Reset state to the rest of the chip |
| rst_line_pull_low | output | 1 | Enable of the open-drain pull-down on the shared line |
| mains_ok | output | 1 | Low while running from the backup battery |
| boot_req | output | 1 | One-cycle bootstrap-load request |

## Verification
Two events can land on the same edge. A fresh warning crossing can set the request in the cycle where software acknowledges the previous one. A cause that returns can also meet a power-on count that is close to running out. The bench leaves a request pending, lets the warning flag drop and rise again, and places the acknowledge on the exact edge where the second set takes effect. The request must stay pending. In a separate run, the minimum-level flag returns part-way through the delay, and the reset must outlast the end point the first count would have reached. A behavioural model of the line, which includes the echo of the block's own pull, is compared with every output on every cycle.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    // synchronized view of all asynchronous inputs; prog_n is bit 0
    typedef struct packed {
        logic vwarn;
        logic vmin;
        logic vbat;
        logic ext_low;
        logic prog_n;
    } pfs_sync_t;

    localparam int unsigned SYNC_W = $bits(pfs_sync_t);
    localparam logic [SYNC_W-1:0] SYNC_RST = 5'b00001;

    typedef struct packed {
        logic pull_low;
        logic mains_ok;
        logic prog_prev;
        logic boot;
    } pfs_top_st_t;

    typedef struct packed {
        logic pending;
        logic armed;
    } pfs_irq_st_t;

endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
    parameter int unsigned          W       = 1,
    parameter int unsigned          STAGES  = 2,
    parameter logic [W-1:0]         RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign dout[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/pfs_por_timer.sv
module pfs_por_timer #(
    parameter int unsigned LIMIT = 21504
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic busy
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hold)                cnt_d = '0;
        else if (cnt_q != LIM_V) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != LIM_V);

    // R7
    restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> busy);

    // R6
    release_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(hold));
endmodule

// File: rtl/pfs_warn_irq.sv
module pfs_warn_irq
    import pfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic warn_s,
    input  logic en,
    input  logic ack,
    output logic pending
);
    pfs_irq_st_t st_d, st_q;
    logic        set_w;

    always_comb begin
        set_w      = warn_s & en & st_q.armed;
        st_d       = st_q;
        st_d.pending = set_w | (st_q.pending & ~ack);
        if (set_w)       st_d.armed = 1'b0;
        else if (!warn_s) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pending: 1'b0, armed: 1'b1};
        else        st_q <= st_d;
    end

    assign pending = st_q.pending;

    // R2
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> ($past(en) && $past(warn_s)));

    // R3
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(ack));
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
    import pfs_pkg::*;
#(
    parameter int unsigned POR_CYCLES  = 21504,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [7:0]  IRQ_VECTOR  = 8'h2B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vwarn_low_a,
    input  logic       vmin_low_a,
    input  logic       vbat_low_a,
    input  logic       warn_irq_en,
    input  logic       warn_irq_ack,
    input  logic       prog_req_n_a,
    input  logic       rst_line_in,
    output logic       warn_irq,
    output logic [7:0] warn_irq_vec,
    output logic       sys_reset,
    output logic       rst_line_pull_low,
    output logic       mains_ok,
    output logic       boot_req
);
    pfs_sync_t   raw_w, syn_w;
    pfs_top_st_t st_d, st_q;
    logic        cause_w;
    logic        busy_w;
    logic        pend_w;

    always_comb begin
        raw_w.vwarn   = vwarn_low_a;
        raw_w.vmin    = vmin_low_a;
        raw_w.vbat    = vbat_low_a;
        raw_w.ext_low = ~rst_line_in;
        raw_w.prog_n  = prog_req_n_a;
    end

    pfs_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_w),
        .dout  (syn_w)
    );

    assign cause_w = syn_w.vmin | syn_w.ext_low;

    pfs_por_timer #(
        .LIMIT (POR_CYCLES)
    ) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (cause_w),
        .busy  (busy_w)
    );

    pfs_warn_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .warn_s  (syn_w.vwarn),
        .en      (warn_irq_en),
        .ack     (warn_irq_ack),
        .pending (pend_w)
    );

    always_comb begin
        st_d           = st_q;
        st_d.pull_low  = syn_w.vmin;
        st_d.mains_ok  = ~syn_w.vbat;
        st_d.prog_prev = syn_w.prog_n;
        st_d.boot      = st_q.prog_prev & ~syn_w.prog_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pull_low: 1'b0, mains_ok: 1'b1, prog_prev: 1'b1, boot: 1'b0};
        else        st_q <= st_d;
    end

    assign sys_reset         = busy_w;
    assign rst_line_pull_low = st_q.pull_low;
    assign mains_ok          = st_q.mains_ok;
    assign boot_req          = st_q.boot;
    assign warn_irq          = pend_w;
    assign warn_irq_vec      = pend_w ? IRQ_VECTOR : 8'h00;

    // R4
    pull_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_line_pull_low |-> sys_reset);

    // R9
    boot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_req |=> !boot_req);
endmodule

// File: tb/pfs_supervisor_bench.sv
module pfs_supervisor_bench;
    localparam int POR = 21504;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vwarn = 1'b0, vmin = 1'b0, vbat = 1'b0;
    logic en = 1'b0, ack = 1'b0, prog_n = 1'b1, tb_pull = 1'b0;
    logic irq, rst_o, pull_o, mains_o, boot_o;
    logic [7:0] vec;
    wire  line = ~(pull_o | tb_pull);

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pfs_supervisor u_pfs_supervisor (
        .clk(clk), .rst_n(rst_n),
        .vwarn_low_a(vwarn), .vmin_low_a(vmin), .vbat_low_a(vbat),
        .warn_irq_en(en), .warn_irq_ack(ack), .prog_req_n_a(prog_n),
        .rst_line_in(line),
        .warn_irq(irq), .warn_irq_vec(vec), .sys_reset(rst_o),
        .rst_line_pull_low(pull_o), .mains_ok(mains_o), .boot_req(boot_o)
    );

    // behavioural reference: per-input delay queues and plain integers
    bit q_warn[$], q_min[$], q_bat[$], q_ext[$], q_prog[$];
    int m_cnt = 0;
    bit m_pend = 0, m_arm = 1, m_pull = 0, m_mains = 1, m_boot = 0, m_prev = 1;

    task automatic clear_model();
        q_warn = '{0, 0}; q_min = '{0, 0}; q_bat = '{0, 0};
        q_ext = '{0, 0}; q_prog = '{1, 1};
        m_cnt = 0; m_pend = 0; m_arm = 1; m_pull = 0; m_mains = 1; m_boot = 0; m_prev = 1;
    endtask

    initial clear_model();

    always @(posedge clk) begin
        if (!rst_n) clear_model();
        else begin
            bit w, mn, b, e, p, setv;
            w = q_warn[0]; mn = q_min[0]; b = q_bat[0]; e = q_ext[0]; p = q_prog[0];
            if (mn || e) m_cnt = 0;
            else if (m_cnt < POR) m_cnt++;
            setv = w && en && m_arm;
            m_pend = setv || (m_pend && !ack);
            if (setv) m_arm = 0; else if (!w) m_arm = 1;
            m_pull = mn; m_mains = !b;
            m_boot = m_prev && !p; m_prev = p;
            void'(q_warn.pop_front()); q_warn.push_back(vwarn);
            void'(q_min.pop_front());  q_min.push_back(vmin);
            void'(q_bat.pop_front());  q_bat.push_back(vbat);
            void'(q_ext.pop_front());  q_ext.push_back(!line);
            void'(q_prog.pop_front()); q_prog.push_back(prog_n);
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            chk("R6", {7'd0, rst_o}, {7'd0, m_cnt != POR});
            chk("R4", {7'd0, pull_o}, {7'd0, m_pull});
            chk("R8", {7'd0, mains_o}, {7'd0, m_mains});
            chk("R2", {7'd0, irq}, {7'd0, m_pend});
            chk("R2", vec, m_pend ? 8'h2B : 8'h00);
            chk("R9", {7'd0, boot_o}, {7'd0, m_boot});
        end
        if (cyc > 190000 && !done) begin
            done = 1;
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(2);
        // R10 reset state
        chk("R10", {7'd0, rst_o}, 8'd1);
        chk("R10", {7'd0, irq}, 8'd0);
        chk("R10", {7'd0, pull_o}, 8'd0);
        chk("R10", {7'd0, mains_o}, 8'd1);
        rst_n = 1'b1;
        step(POR + 4);
        chk("R6", {7'd0, rst_o}, 8'd0);

        // R1 latency of the synchronizer
        vbat = 1'b1; step(2);
        chk("R1", {7'd0, mains_o}, 8'd1);
        step(1);
        chk("R1", {7'd0, mains_o}, 8'd0);
        vbat = 1'b0; step(4);

        // R2 / R3 warning interrupt
        en = 1'b1; vwarn = 1'b1; step(3);
        chk("R2", {7'd0, irq}, 8'd1);
        chk("R2", vec, 8'h2B);
        ack = 1'b1; step(1); ack = 1'b0;
        chk("R3", {7'd0, irq}, 8'd0);
        step(5);
        chk("R3", {7'd0, irq}, 8'd0);
        vwarn = 1'b0; step(5);
        vwarn = 1'b1; step(3);
        chk("R2", {7'd0, irq}, 8'd1);
        vwarn = 1'b0; step(5);
        vwarn = 1'b1; step(2);
        ack = 1'b1; step(1); ack = 1'b0;   // ack on the set edge
        chk("R3", {7'd0, irq}, 8'd1);
        ack = 1'b1; step(1); ack = 1'b0;
        chk("R3", {7'd0, irq}, 8'd0);
        vwarn = 1'b0; step(5);
        en = 1'b0; vwarn = 1'b1; step(6);
        chk("R2", {7'd0, irq}, 8'd0);
        en = 1'b1; step(1);
        chk("R2", {7'd0, irq}, 8'd1);
        ack = 1'b1; step(1); ack = 1'b0;
        vwarn = 1'b0; step(4);

        // R9 bootstrap request edge
        prog_n = 1'b0; step(3);
        chk("R9", {7'd0, boot_o}, 8'd1);
        step(1);
        chk("R9", {7'd0, boot_o}, 8'd0);
        prog_n = 1'b1; step(3);
        chk("R9", {7'd0, boot_o}, 8'd0);
        step(2);

        // R4 / R7 / R6 supply dip with early return
        vmin = 1'b1; step(10);
        chk("R4", {7'd0, rst_o}, 8'd1);
        chk("R4", {7'd0, pull_o}, 8'd1);
        vmin = 1'b0; step(1000);
        vmin = 1'b1; step(5); vmin = 1'b0;
        step(21000);
        chk("R7", {7'd0, rst_o}, 8'd1);
        step(600);
        chk("R6", {7'd0, rst_o}, 8'd0);

        // R5 external pull on the shared line
        tb_pull = 1'b1; step(6);
        chk("R5", {7'd0, rst_o}, 8'd1);
        chk("R5", {7'd0, pull_o}, 8'd0);
        tb_pull = 1'b0; step(POR + 6);
        chk("R5", {7'd0, rst_o}, 8'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule